// File: doc/BRIEF.md
# Status Indicator Pull-Down Driver

This block produces the three active-low, open-drain indicator outputs of a network controller. Each output is presented as a pull enable: a 1 asks the pad to pull the pin low, a 0 leaves it released. The link indicator reports link-pulse status. The bus indicator reports host bus accesses that the receiver triggers. The activity indicator is stretched so that a short receive, transmit or collision event stays visible for a long time.

The link and bus indicators can each be handed to the host as plain general-purpose outputs. A per-pin override enable selects the host source, and a per-pin override value then sets the level directly. In the hardware standby mode the activity indicator stops stretching and follows the receiver's activity sense directly. The stretch length is a parameter. Its default of 120,000 cycles gives 6 ms at a 20 MHz reference clock.

Top module: `stat_led_drv`

## Requirements
- R1: A pull output of 1 means the pin is driven low, and 0 means released. The reset input is synchronous and active-high, and on the first clock edge with reset high all three pull outputs go to 0.
- R2: While `ovr_en_i[0]` is 0, `link_pull_o` equals the `link_good_i` value sampled at the previous clock edge.
- R3: While `ovr_en_i[0]` is 1, `link_pull_o` equals the `ovr_val_i[0]` value sampled at the previous edge, and `link_good_i` has no effect.
- R4: While `ovr_en_i[1]` is 0, `bus_pull_o` equals the `rx_bus_acc_i` value sampled at the previous edge.
- R5: While `ovr_en_i[1]` is 1, `bus_pull_o` equals the `ovr_val_i[1]` value sampled at the previous edge, and `rx_bus_acc_i` has no effect.
- R6: Outside standby, a 1 on any of `rx_evt_i`, `tx_evt_i` or `coll_evt_i` at an edge sets `act_pull_o` to 1 from that edge onward for exactly STRETCH_CYC cycles. After that it returns to 0.
- R7: An event that arrives while a stretch is running restarts the full STRETCH_CYC count from that edge, so the output stays at 1 without a gap.
- R8: While `standby_i` is 1, `act_pull_o` equals the `rx_sense_i` value sampled at the previous edge, and the event inputs have no effect.
- R9: Entering standby discards any running stretch. At the first edge after standby ends, `act_pull_o` is 0 unless an event is sampled at that same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| link_good_i | input | 1 | Valid link pulses are present |
| rx_bus_acc_i | input | 1 | Receive activity is causing a host bus access |
| rx_evt_i | input | 1 | Receive packet event strobe |
| tx_evt_i | input | 1 | Transmit packet event strobe |
| coll_evt_i | input | 1 | Collision event strobe |
| standby_i | input | 1 | Hardware standby mode flag |
| rx_sense_i | input | 1 | Receiver detects network activity |
| ovr_en_i | input | 2 | Host override enable; bit 0 link pin, bit 1 bus pin |
| ovr_val_i | input | 2 | Host override value; 1 pulls the pin low |
| link_pull_o | output | 1 | Link pin pull-low enable |
| bus_pull_o | output | 1 | Bus-status pin pull-low enable |
| act_pull_o | output | 1 | Activity pin pull-low enable |

## Verification
A wrong source selection on the link or bus pin appears at the port one cycle after the inputs change. The bench therefore sweeps every combination of override enable, override value and status input for both pins. A stretch counter that loads the wrong length, decrements at the wrong rate or fails to restart makes the activity pin release a cycle early or late, or drop for a cycle during a retrigger. This shows up within STRETCH_CYC+1 cycles of the last event. Stale counter state that survives standby shows up as a low level on the first cycle after standby ends.

// File: rtl/stat_led_pkg.sv
package stat_led_pkg;

    localparam int unsigned REF_CLK_KHZ     = 20000;
    localparam int unsigned ACT_HOLD_MS     = 6;
    localparam int unsigned DEF_STRETCH_CYC = REF_CLK_KHZ * ACT_HOLD_MS;

    localparam int unsigned N_OVR_PINS = 2;

    typedef enum logic {
        SRC_AUTO = 1'b0,
        SRC_HOST = 1'b1
    } pin_src_e;

    typedef struct packed {
        logic en;
        logic val;
    } host_ovr_t;

    typedef struct packed {
        logic link;
        logic bus;
        logic act;
    } pull_set_t;

    function automatic pin_src_e src_of(host_ovr_t o);
        return o.en ? SRC_HOST : SRC_AUTO;
    endfunction

    function automatic logic pick_level(host_ovr_t o, logic auto_lvl);
        return (src_of(o) == SRC_HOST) ? o.val : auto_lvl;
    endfunction

endpackage

// File: rtl/stat_ovr_pin.sv
module stat_ovr_pin
    import stat_led_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  host_ovr_t ovr_i,
    input  logic      auto_i,
    output logic      pull_o
);

    logic pull_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pull_q <= 1'b0;
        end else begin
            pull_q <= pick_level(ovr_i, auto_i);
        end
    end

    assign pull_o = pull_q;

endmodule

// File: rtl/stat_act_stretch.sv
module stat_act_stretch #(
    parameter int unsigned STRETCH_CYC = stat_led_pkg::DEF_STRETCH_CYC
) (
    input  logic clk,
    input  logic rst,
    input  logic evt_i,
    input  logic standby_i,
    input  logic sense_i,
    output logic pull_o
);

    localparam int unsigned CW = $clog2(STRETCH_CYC + 1);
    localparam logic [CW-1:0] LOAD_VAL = CW'(STRETCH_CYC);

    logic [CW-1:0] cnt_q;
    logic          sb_q;
    logic          sense_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q   <= '0;
            sb_q    <= 1'b0;
            sense_q <= 1'b0;
        end else begin
            sb_q    <= standby_i;
            sense_q <= sense_i;
            if (standby_i) begin
                cnt_q <= '0;
            end else if (evt_i) begin
                cnt_q <= LOAD_VAL;
            end else if (cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    assign pull_o = sb_q ? sense_q : (cnt_q != '0);

    // R6: the counter drains by one per idle cycle
    p_drain_step_r6: assert property (@(posedge clk) disable iff (rst)
        (!standby_i && !evt_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

    // R6: the final count releases the pin at the next edge
    p_release_end_r6: assert property (@(posedge clk) disable iff (rst)
        (!standby_i && !evt_i && cnt_q == 1) |=> !pull_o);

    // R7: an event always refills the stretch
    p_refill_r7: assert property (@(posedge clk) disable iff (rst)
        (!standby_i && evt_i) |=> (pull_o && cnt_q == LOAD_VAL));

    // R9: no count survives standby
    p_sb_clear_r9: assert property (@(posedge clk) disable iff (rst)
        standby_i |=> (cnt_q == '0));

endmodule

// File: rtl/stat_led_drv.sv
module stat_led_drv
    import stat_led_pkg::*;
#(
    parameter int unsigned STRETCH_CYC = stat_led_pkg::DEF_STRETCH_CYC
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       link_good_i,
    input  logic       rx_bus_acc_i,
    input  logic       rx_evt_i,
    input  logic       tx_evt_i,
    input  logic       coll_evt_i,
    input  logic       standby_i,
    input  logic       rx_sense_i,
    input  logic [1:0] ovr_en_i,
    input  logic [1:0] ovr_val_i,
    output logic       link_pull_o,
    output logic       bus_pull_o,
    output logic       act_pull_o
);

    logic [N_OVR_PINS-1:0] auto_lvl;
    logic [N_OVR_PINS-1:0] pin_pull;
    logic                  any_evt;
    pull_set_t             pulls;

    assign auto_lvl[0] = link_good_i;
    assign auto_lvl[1] = rx_bus_acc_i;
    assign any_evt     = rx_evt_i | tx_evt_i | coll_evt_i;

    for (genvar p = 0; p < N_OVR_PINS; p++) begin : g_pin
        host_ovr_t ovr;
        assign ovr.en  = ovr_en_i[p];
        assign ovr.val = ovr_val_i[p];

        stat_ovr_pin u_pin (
            .clk    (clk),
            .rst    (rst),
            .ovr_i  (ovr),
            .auto_i (auto_lvl[p]),
            .pull_o (pin_pull[p])
        );
    end

    stat_act_stretch #(
        .STRETCH_CYC (STRETCH_CYC)
    ) u_act (
        .clk       (clk),
        .rst       (rst),
        .evt_i     (any_evt),
        .standby_i (standby_i),
        .sense_i   (rx_sense_i),
        .pull_o    (pulls.act)
    );

    assign pulls.link = pin_pull[0];
    assign pulls.bus  = pin_pull[1];

    assign link_pull_o = pulls.link;
    assign bus_pull_o  = pulls.bus;
    assign act_pull_o  = pulls.act;

    p_link_auto_r2: assert property (@(posedge clk) disable iff (rst)
        !ovr_en_i[0] |=> (link_pull_o == $past(link_good_i)));

    p_link_host_r3: assert property (@(posedge clk) disable iff (rst)
        ovr_en_i[0] |=> (link_pull_o == $past(ovr_val_i[0])));

    p_bus_auto_r4: assert property (@(posedge clk) disable iff (rst)
        !ovr_en_i[1] |=> (bus_pull_o == $past(rx_bus_acc_i)));

    p_bus_host_r5: assert property (@(posedge clk) disable iff (rst)
        ovr_en_i[1] |=> (bus_pull_o == $past(ovr_val_i[1])));

    p_evt_asserts_r6: assert property (@(posedge clk) disable iff (rst)
        (!standby_i && any_evt) |=> act_pull_o);

    p_sb_follow_r8: assert property (@(posedge clk) disable iff (rst)
        standby_i |=> (act_pull_o == $past(rx_sense_i)));

    p_sb_exit_r9: assert property (@(posedge clk) disable iff (rst)
        ($fell(standby_i) && !any_evt) |=> !act_pull_o);

endmodule

// File: tb/stat_led_drv_tb_top.sv
module stat_led_drv_tb_top;

    localparam int unsigned S = 5;

    logic       clk = 1'b0;
    logic       rst;
    logic       link_good_i, rx_bus_acc_i, rx_evt_i, tx_evt_i, coll_evt_i;
    logic       standby_i, rx_sense_i;
    logic [1:0] ovr_en_i, ovr_val_i;
    logic       link_pull_o, bus_pull_o, act_pull_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    stat_led_drv #(.STRETCH_CYC(S)) dut_i (
        .clk(clk), .rst(rst),
        .link_good_i(link_good_i), .rx_bus_acc_i(rx_bus_acc_i),
        .rx_evt_i(rx_evt_i), .tx_evt_i(tx_evt_i), .coll_evt_i(coll_evt_i),
        .standby_i(standby_i), .rx_sense_i(rx_sense_i),
        .ovr_en_i(ovr_en_i), .ovr_val_i(ovr_val_i),
        .link_pull_o(link_pull_o), .bus_pull_o(bus_pull_o), .act_pull_o(act_pull_o)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic fire(input int kind);
        rx_evt_i   = (kind == 0);
        tx_evt_i   = (kind == 1);
        coll_evt_i = (kind == 2);
        step();
        rx_evt_i = 0; tx_evt_i = 0; coll_evt_i = 0;
    endtask

    initial begin
        rst = 1; link_good_i = 1; rx_bus_acc_i = 1; rx_evt_i = 1; tx_evt_i = 0;
        coll_evt_i = 0; standby_i = 0; rx_sense_i = 1; ovr_en_i = 2'b00; ovr_val_i = 2'b11;
        @(negedge clk);
        step();
        // R1: reset releases all pins
        chk("R1 link", link_pull_o, 1'b0);
        chk("R1 bus",  bus_pull_o,  1'b0);
        chk("R1 act",  act_pull_o,  1'b0);
        rx_evt_i = 0; rx_sense_i = 0;
        rst = 0;
        step();

        // R2..R5: full sweep of source selection for both pins
        for (int v = 0; v < 64; v++) begin
            ovr_en_i[0] = v[0]; ovr_val_i[0] = v[1]; link_good_i  = v[2];
            ovr_en_i[1] = v[3]; ovr_val_i[1] = v[4]; rx_bus_acc_i = v[5];
            step();
            chk(v[0] ? "R3 link host" : "R2 link auto", link_pull_o, v[0] ? v[1] : v[2]);
            chk(v[3] ? "R5 bus host"  : "R4 bus auto",  bus_pull_o,  v[3] ? v[4] : v[5]);
        end
        ovr_en_i = 0;

        // R6: single event of each kind, exact stretch length
        for (int k = 0; k < 3; k++) begin
            fire(k);
            for (int j = 1; j <= S + 2; j++) begin
                chk("R6 stretch", act_pull_o, (j <= S));
                step();
            end
        end

        // R7: retrigger after 3 cycles, no gap, full length from the second event
        fire(0);
        step(); step();
        chk("R7 mid", act_pull_o, 1'b1);
        fire(2);
        for (int j = 1; j <= S + 1; j++) begin
            chk("R7 restart", act_pull_o, (j <= S));
            step();
        end

        // R8: standby follows sense, events ignored
        standby_i = 1;
        for (int v = 0; v < 8; v++) begin
            rx_sense_i = v[0];
            rx_evt_i = v[1]; tx_evt_i = v[2]; coll_evt_i = v[1] & v[2];
            step();
            chk("R8 follow", act_pull_o, v[0]);
        end
        rx_evt_i = 0; tx_evt_i = 0; coll_evt_i = 0; rx_sense_i = 0;
        standby_i = 0;
        step();

        // R9: enter standby mid-stretch, leave standby, expect release
        fire(1);
        step();
        standby_i = 1; rx_sense_i = 0;
        step();
        chk("R9 sb clears", act_pull_o, 1'b0);
        standby_i = 0;
        step();
        chk("R9 exit released", act_pull_o, 1'b0);
        step();
        chk("R9 stays released", act_pull_o, 1'b0);

        // R9: event on the standby exit edge loads a full stretch
        standby_i = 1; step();
        standby_i = 0; tx_evt_i = 1;
        step();
        tx_evt_i = 0;
        for (int j = 1; j <= S + 1; j++) begin
            chk("R9 exit with event", act_pull_o, (j <= S));
            step();
        end

        // R1: reset mid-stretch releases
        fire(0);
        rst = 1;
        step();
        chk("R1 reset mid-stretch", act_pull_o, 1'b0);
        rst = 0;
        step();
        chk("R1 after reset", act_pull_o, 1'b0);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

endmodule